// File: doc/BRIEF.md
# Timed Event Code Sequencer

This block plays back a stored list of timed event codes once a trigger arrives. Each entry of a 2048-deep sequence memory holds a 32-bit absolute timestamp and an 8-bit event code. Software fills the memory through a single-cycle write port. When the sequencer is armed, idle and triggered, it clears its timestamp counter and starts reading at address 0. The timestamp counter advances once every `presc_ratio` clocks. Each entry's code is presented on the event output as soon as the counter has reached that entry's timestamp.

The trigger comes from one of four sources, chosen by `trig_sel`: a software strobe, a rising edge on an external input, a rising edge on a counter output, or the line-sync input after a programmable edge divider. Two code values are reserved. 0x00 fills a time slot and puts nothing on the output. 0x7F closes the sequence. At the close, the `recycle` setting decides whether the sequencer stays armed for the next trigger or needs a fresh `arm` strobe.

Top module: `evseq_top`

## Requirements
- R1: After a synchronous active-low reset, `evt_valid` is 0, `evt_code` is 0x00, `busy` is 0 and the sequencer is not armed.
- R2: A trigger starts a sequence only when the sequencer is armed and idle. `arm` is a one-cycle strobe that arms it. When a source event is presented before clock edge A, `busy` is high after edge A+1.
- R3: Let t_i be the slot of entry i, counted in clock edges after `busy` rises, and let r be the prescaler ratio. Then t_i = max(ts_i·r + 1, t_(i-1) + 1), with t_(-1) = 0. The entry's code appears on the output after edge A+1+t_i and stays valid for one cycle.
- R4: A `presc_ratio` of 0 gives the same timing as a ratio of 1.
- R5: An entry with code 0x00 takes up its slot and does not raise `evt_valid`.
- R6: An entry with code 0x7F ends the sequence in its slot. `busy` is low after that slot's edge, and 0x7F is never output.
- R7: When a sequence ends, the sequencer stays armed if `recycle` is 1. If `recycle` is 0 it is disarmed, and later triggers are ignored until the next `arm` strobe.
- R8: A trigger that arrives while `busy` is high has no effect on the running sequence.
- R9: `trig_sel` encodes the source as 0 = software strobe, 1 = external rising edge, 2 = counter-output rising edge, 3 = divided line-sync. Events on sources that are not selected are ignored.
- R10: When `line_div` = v, every (v+1)-th rising edge of `line_sync` since reset produces a trigger. This gives a divide ratio from 1 to 256.
- R11: Entries whose timestamps have already passed are output on consecutive cycles, one per cycle.
- R12: If no 0x7F is met, the sequence ends after the entry at address 2047 has been played.
- R13: While `evt_valid` is 0, `evt_code` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the sequence memory |
| wr_addr | input | 11 | Entry address to write |
| wr_ts | input | 32 | Timestamp to store |
| wr_code | input | 8 | Event code to store |
| presc_ratio | input | 16 | Event clocks per timestamp tick (0 acts as 1) |
| trig_sel | input | 2 | Trigger source select |
| line_div | input | 8 | Line-sync divide ratio minus one |
| recycle | input | 1 | Stay armed when the sequence ends |
| arm | input | 1 | Arm strobe |
| sw_trig | input | 1 | Software trigger strobe |
| ext_trig | input | 1 | External trigger level |
| cnt_trig | input | 1 | Counter output level |
| line_sync | input | 1 | Line-sync level |
| evt_valid | output | 1 | Event code strobe |
| evt_code | output | 8 | Emitted event code |
| busy | output | 1 | Sequence in progress |

## Verification
The assertions check on every cycle that the code is zero when `evt_valid` is low, that 0x00 and 0x7F never appear as valid events, that events are only produced while a sequence runs, that a sequence starts only from the armed state, and that the armed state after the end follows `recycle`. The exact slot timing depends on the stored timestamps and the prescaler ratio, so only the bench scenarios can show it. The same holds for the effect of ignored triggers, the source selection, the line-sync division count and the implicit end at the last address. The bench computes those schedules cycle by cycle.

// File: rtl/evseq_pkg.sv
// Shared definitions for the event sequencer: trigger source encoding
// and the two reserved event code values.
package evseq_pkg;

    typedef enum logic [1:0] {
        SRC_SOFT  = 2'd0,
        SRC_EXT   = 2'd1,
        SRC_COUNT = 2'd2,
        SRC_LINE  = 2'd3
    } trig_src_e;

    localparam logic [7:0] CODE_NULL = 8'h00;
    localparam logic [7:0] CODE_END  = 8'h7F;

endpackage

// File: rtl/evseq_mem.sv
// Sequence memory: DEPTH entries of {timestamp, code}.
// Synchronous write and combinational read, so the playback engine can
// compare the current entry in the cycle its address is presented.
// Assumes: no read/write collision rules are needed; a write to the
// entry being read shows up on the next cycle.
module evseq_mem #(
    parameter int unsigned DEPTH  = 2048,
    parameter int unsigned TS_W   = 32,
    parameter int unsigned CODE_W = 8,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [TS_W-1:0]   wr_ts,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [TS_W-1:0]   rd_ts,
    output logic [CODE_W-1:0] rd_code
);

    logic [TS_W-1:0]   ts_store   [DEPTH];
    logic [CODE_W-1:0] code_store [DEPTH];

    // Store one entry per write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            ts_store[wr_addr]   <= wr_ts;
            code_store[wr_addr] <= wr_code;
        end
    end

    assign rd_ts   = ts_store[rd_addr];
    assign rd_code = code_store[rd_addr];

endmodule

// File: rtl/evseq_prescaler.sv
// Timestamp prescaler: gives a one-cycle tick every `ratio` enabled
// clocks. A ratio of 0 is treated as 1. `clr` restarts the count so the
// first tick of a sequence comes `ratio` enabled clocks after the start.
module evseq_prescaler #(
    parameter int unsigned PRESC_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               en,
    input  logic [PRESC_W-1:0] ratio,
    output logic               tick
);

    logic [PRESC_W-1:0] cnt_q;
    logic [PRESC_W-1:0] last_val;

    // Terminal count: ratio-1, with 0 folded onto 1.
    always_comb begin
        last_val = (ratio == '0) ? '0 : ratio - 1'b1;
    end

    assign tick = en && (cnt_q == last_val);

    // Divider count; cleared on start, advances only while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/evseq_trig_sel.sv
// Trigger selector: detects rising edges on the external and counter
// inputs, divides line-sync rising edges by (div+1), and registers the
// event of the selected source as a single-cycle trigger.
// Assumes: all inputs are already synchronous to clk.
module evseq_trig_sel
    import evseq_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sel,
    input  logic [DIV_W-1:0] line_div,
    input  logic             sw_trig,
    input  logic             ext_trig,
    input  logic             cnt_trig,
    input  logic             line_sync,
    output logic             trig
);

    logic             ext_q, cnt_q, line_q;
    logic             ext_rise, cnt_rise, line_rise;
    logic [DIV_W-1:0] line_cnt_q;
    logic             line_pulse;
    logic             chosen;

    assign ext_rise   = ext_trig  && !ext_q;
    assign cnt_rise   = cnt_trig  && !cnt_q;
    assign line_rise  = line_sync && !line_q;
    assign line_pulse = line_rise && (line_cnt_q == line_div);

    // Previous levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q  <= 1'b0;
            cnt_q  <= 1'b0;
            line_q <= 1'b0;
        end else begin
            ext_q  <= ext_trig;
            cnt_q  <= cnt_trig;
            line_q <= line_sync;
        end
    end

    // Line-sync edge divider; wraps on the (div+1)-th edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_cnt_q <= '0;
        end else if (line_rise) begin
            line_cnt_q <= line_pulse ? '0 : line_cnt_q + 1'b1;
        end
    end

    // Source multiplexer.
    always_comb begin
        unique case (trig_src_e'(sel))
            SRC_SOFT:  chosen = sw_trig;
            SRC_EXT:   chosen = ext_rise;
            SRC_COUNT: chosen = cnt_rise;
            SRC_LINE:  chosen = line_pulse;
            default:   chosen = 1'b0;
        endcase
    end

    // Register the selected event as a single-cycle trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) trig <= 1'b0;
        else        trig <= chosen;
    end

endmodule

// File: rtl/evseq_engine.sv
// Playback engine: on an accepted trigger clears the timestamp counter
// and address, then walks the memory, handling at most one entry per
// cycle once the counter has reached the entry's timestamp. Null codes
// are consumed silently; the end code or the last address closes the run.
// Assumes: entries are stored in ascending timestamp order.
module evseq_engine
    import evseq_pkg::*;
#(
    parameter int unsigned DEPTH  = 2048,
    parameter int unsigned TS_W   = 32,
    parameter int unsigned CODE_W = 8,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic              arm,
    input  logic              recycle,
    input  logic              tick,
    input  logic [TS_W-1:0]   ent_ts,
    input  logic [CODE_W-1:0] ent_code,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              start,
    output logic              busy,
    output logic              armed,
    output logic              evt_valid,
    output logic [CODE_W-1:0] evt_code
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    logic [TS_W-1:0] ts_cnt_q;
    logic            hit, is_end, is_null, finish;

    assign start   = trig && armed && !busy;
    assign hit     = busy && (ts_cnt_q >= ent_ts);
    assign is_end  = (ent_code == CODE_END);
    assign is_null = (ent_code == CODE_NULL);
    assign finish  = hit && (is_end || rd_addr == LAST_ADDR);

    // Run state, address and timestamp counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            rd_addr  <= '0;
            ts_cnt_q <= '0;
        end else if (start) begin
            busy     <= 1'b1;
            rd_addr  <= '0;
            ts_cnt_q <= '0;
        end else if (busy) begin
            if (tick)   ts_cnt_q <= ts_cnt_q + 1'b1;
            if (hit)    rd_addr  <= rd_addr + 1'b1;
            if (finish) busy     <= 1'b0;
        end
    end

    // Arm flag: set by strobe, reloaded from recycle at sequence end.
    always_ff @(posedge clk) begin
        if (!rst_n)      armed <= 1'b0;
        else if (arm)    armed <= 1'b1;
        else if (finish) armed <= recycle;
    end

    // Registered event output; idle cycles carry the null code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid <= 1'b0;
            evt_code  <= CODE_NULL;
        end else if (hit && !is_end && !is_null) begin
            evt_valid <= 1'b1;
            evt_code  <= ent_code;
        end else begin
            evt_valid <= 1'b0;
            evt_code  <= CODE_NULL;
        end
    end

endmodule

// File: rtl/evseq_top.sv
// Event sequencer top: trigger selection, prescaler, sequence memory and
// playback engine. Assumes synchronous inputs and one clock domain.
module evseq_top #(
    parameter int unsigned DEPTH   = 2048,
    parameter int unsigned TS_W    = 32,
    parameter int unsigned CODE_W  = 8,
    parameter int unsigned PRESC_W = 16,
    parameter int unsigned DIV_W   = 8,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [TS_W-1:0]    wr_ts,
    input  logic [CODE_W-1:0]  wr_code,
    input  logic [PRESC_W-1:0] presc_ratio,
    input  logic [1:0]         trig_sel,
    input  logic [DIV_W-1:0]   line_div,
    input  logic               recycle,
    input  logic               arm,
    input  logic               sw_trig,
    input  logic               ext_trig,
    input  logic               cnt_trig,
    input  logic               line_sync,
    output logic               evt_valid,
    output logic [CODE_W-1:0]  evt_code,
    output logic               busy
);

    logic              trig, tick, start, armed;
    logic [ADDR_W-1:0] rd_addr;
    logic [TS_W-1:0]   ent_ts;
    logic [CODE_W-1:0] ent_code;

    evseq_trig_sel #(.DIV_W(DIV_W)) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (trig_sel),
        .line_div  (line_div),
        .sw_trig   (sw_trig),
        .ext_trig  (ext_trig),
        .cnt_trig  (cnt_trig),
        .line_sync (line_sync),
        .trig      (trig)
    );

    evseq_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .en    (busy),
        .ratio (presc_ratio),
        .tick  (tick)
    );

    evseq_mem #(.DEPTH(DEPTH), .TS_W(TS_W), .CODE_W(CODE_W)) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_ts   (wr_ts),
        .wr_code (wr_code),
        .rd_addr (rd_addr),
        .rd_ts   (ent_ts),
        .rd_code (ent_code)
    );

    evseq_engine #(.DEPTH(DEPTH), .TS_W(TS_W), .CODE_W(CODE_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .arm       (arm),
        .recycle   (recycle),
        .tick      (tick),
        .ent_ts    (ent_ts),
        .ent_code  (ent_code),
        .rd_addr   (rd_addr),
        .start     (start),
        .busy      (busy),
        .armed     (armed),
        .evt_valid (evt_valid),
        .evt_code  (evt_code)
    );

endmodule

// File: rtl/evseq_checks.sv
// Property checker for the event sequencer, bound to evseq_top.
module evseq_checks #(
    parameter int unsigned CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              evt_valid,
    input logic [CODE_W-1:0] evt_code,
    input logic              busy,
    input logic              armed,
    input logic              arm,
    input logic              recycle
);

    // R13: idle cycles carry the null code.
    a_r13_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_valid |-> evt_code == '0);

    // R5: a null entry never shows up as a valid event.
    a_r5_no_null_out: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> evt_code != '0);

    // R6: the end code is never emitted.
    a_r6_no_end_out: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> evt_code != CODE_W'(8'h7F));

    // R3: events only come from a running sequence.
    a_r3_event_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> $past(busy));

    // R2: a run starts only from the armed state.
    a_r2_start_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(armed));

    // R7: the armed state after the end follows recycle (or a new arm).
    a_r7_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> armed == ($past(recycle) || $past(arm)));

endmodule

bind evseq_top evseq_checks #(.CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_code  (evt_code),
    .busy      (busy),
    .armed     (armed),
    .arm       (arm),
    .recycle   (recycle)
);

// File: tb/evseq_top_tb.sv
module evseq_top_tb;

    localparam int DEPTH = 2048;
    localparam int MAXT  = 4400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [10:0] wr_addr = '0;
    logic [31:0] wr_ts = '0;
    logic [7:0]  wr_code = '0;
    logic [15:0] presc_ratio = 16'd1;
    logic [1:0]  trig_sel = 2'd0;
    logic [7:0]  line_div = 8'd0;
    logic        recycle = 1'b1;
    logic        arm = 1'b0;
    logic        sw_trig = 1'b0, ext_trig = 1'b0, cnt_trig = 1'b0, line_sync = 1'b0;
    logic        evt_valid;
    logic [7:0]  evt_code;
    logic        busy;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] bm_ts   [DEPTH];
    logic [7:0]  bm_code [DEPTH];
    bit          exp_v   [MAXT];
    logic [7:0]  exp_c   [MAXT];
    int          t_end;

    always #2 clk = ~clk;

    evseq_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_ts(wr_ts), .wr_code(wr_code), .presc_ratio(presc_ratio),
        .trig_sel(trig_sel), .line_div(line_div), .recycle(recycle),
        .arm(arm), .sw_trig(sw_trig), .ext_trig(ext_trig),
        .cnt_trig(cnt_trig), .line_sync(line_sync),
        .evt_valid(evt_valid), .evt_code(evt_code), .busy(busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input int a, input logic [31:0] ts, input logic [7:0] c);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 11'(a); wr_ts = ts; wr_code = c;
        bm_ts[a] = ts; bm_code[a] = c;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_arm();
        @(negedge clk); arm = 1'b1;
        @(negedge clk); arm = 1'b0;
    endtask

    task automatic set_src(input int src, input logic v);
        case (src)
            0: sw_trig = v;
            1: ext_trig = v;
            2: cnt_trig = v;
            default: line_sync = v;
        endcase
    endtask

    // Expected schedule from R3/R5/R6/R11/R12: slot t of each entry.
    task automatic build_expected(input int ratio_in);
        int r, t, t_prev, a;
        r = (ratio_in == 0) ? 1 : ratio_in;
        for (int i = 0; i < MAXT; i++) begin exp_v[i] = 0; exp_c[i] = 8'h00; end
        t_prev = 0; a = 0;
        forever begin
            t = int'(bm_ts[a]) * r + 1;
            if (t < t_prev + 1) t = t_prev + 1;
            if (bm_code[a] == 8'h7F) begin t_end = t; break; end
            if (bm_code[a] != 8'h00) begin exp_v[t] = 1; exp_c[t] = bm_code[a]; end
            t_prev = t;
            if (a == DEPTH - 1) begin t_end = t; break; end
            a++;
        end
    endtask

    // Trigger from src and follow the run to its end, checking each cycle.
    task automatic run_seq(input int ratio, input int src, input int inject_k, input string req);
        presc_ratio = 16'(ratio);
        build_expected(ratio);
        @(negedge clk); set_src(src, 1'b1);
        for (int k = 1; k <= t_end + 3; k++) begin
            @(negedge clk);
            if (k == 1) set_src(src, 1'b0);
            if (k == inject_k) set_src(src, 1'b1);
            if (k == inject_k + 1) set_src(src, 1'b0);
            if (k >= 2) begin
                chk({req, " busy"}, 32'(busy), 32'(k < 2 + t_end));
                chk({req, " valid"}, 32'(evt_valid), 32'(exp_v[k-2]));
                chk({req, " code(R13)"}, 32'(evt_code), 32'(exp_c[k-2]));
            end
        end
    endtask

    task automatic expect_idle(input string req);
        repeat (4) @(negedge clk);
        chk(req, 32'(busy), 32'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk("R1 valid", 32'(evt_valid), 0);
        chk("R1 code", 32'(evt_code), 0);
        chk("R1 busy", 32'(busy), 0);

        // Directed sequence with a null and a shared timestamp.
        wr(0, 0, 8'h20); wr(1, 3, 8'h2A); wr(2, 3, 8'h00);
        wr(3, 4, 8'h24); wr(4, 6, 8'h7F);
        // R2: trigger before arming is ignored
        @(negedge clk); sw_trig = 1'b1; @(negedge clk); sw_trig = 1'b0;
        expect_idle("R2 unarmed trigger");

        do_arm();
        recycle = 1'b1;
        // R3 R5 R6 R8: directed run with a trigger injected mid-run
        run_seq(3, 0, 6, "R3/R5/R8");
        // R7: recycle keeps it armed, rerun without arm
        run_seq(2, 0, 0, "R7 recycle");

        recycle = 1'b0;
        run_seq(1, 0, 0, "R6 end");
        @(negedge clk); sw_trig = 1'b1; @(negedge clk); sw_trig = 1'b0;
        expect_idle("R7 disarmed");
        recycle = 1'b1;
        do_arm();

        // R4: ratio 0 equals ratio 1
        run_seq(0, 0, 0, "R4 ratio0");

        // R11: passed timestamps drain one per cycle
        wr(0, 0, 8'h81); wr(1, 0, 8'h82); wr(2, 0, 8'h00); wr(3, 0, 8'h83);
        wr(4, 0, 8'hFE); wr(5, 1, 8'h7F);
        run_seq(4, 0, 0, "R11 back-to-back");

        // R9: unselected sources ignored
        trig_sel = 2'd1;
        @(negedge clk); sw_trig = 1'b1; cnt_trig = 1'b1; line_sync = 1'b1;
        @(negedge clk); sw_trig = 1'b0; cnt_trig = 1'b0; line_sync = 1'b0;
        expect_idle("R9 ext selected");
        run_seq(1, 1, 4, "R9 ext");
        trig_sel = 2'd2;
        @(negedge clk); ext_trig = 1'b1; sw_trig = 1'b1;
        @(negedge clk); ext_trig = 1'b0; sw_trig = 1'b0;
        expect_idle("R9 count selected");
        run_seq(2, 2, 0, "R9 count");

        // R10: line-sync divided by 3
        do_reset();
        do_arm();
        trig_sel = 2'd3; line_div = 8'd2;
        for (int e = 0; e < 2; e++) begin
            @(negedge clk); line_sync = 1'b1; @(negedge clk); line_sync = 1'b0;
            expect_idle("R10 edges before division");
        end
        run_seq(1, 3, 0, "R10 line");
        trig_sel = 2'd0;

        // Random sequences (R3, R5, R11)
        for (int it = 0; it < 12; it++) begin
            int n, ts, src;
            logic [7:0] c;
            n = 1 + int'($urandom % 20);
            ts = 0;
            for (int i = 0; i < n; i++) begin
                ts += int'($urandom % 6);
                c = 8'($urandom % 256);
                if (c == 8'h7F) c = 8'h7E;
                wr(i, ts, c);
            end
            wr(n, ts + int'($urandom % 4), 8'h7F);
            src = int'($urandom % 3);
            trig_sel = 2'(src);
            run_seq(1 + int'($urandom % 4), src, 0, "R3 random");
        end
        trig_sel = 2'd0;

        // R12: full memory without an end code
        for (int i = 0; i < DEPTH; i++) wr(i, 0, 8'(1 + (i % 100)));
        run_seq(1, 0, 0, "R12 last address");

        done = 1;
        summary();
    end

endmodule